// File: doc/BRIEF.md
# Interleaved Dual-Carrier PWM Generator

This block produces the six gate pulses for an interleaved dual-buck inverter that has an unfolding stage. Two triangular carriers are built from up/down counters. Both sweep between zero and a peak count of half a switching period, and they run half a period apart. One duty fraction from an upstream controller drives both of them. The duty is scaled to a compare reference and enters through a valid/ready port into a shadow register. The shadow value is copied to the active compare register only at the valley of carrier A. Each carrier is compared against the active reference, which gives two interleaved PWM waveforms.

A grid-polarity bit selects which switch pair receives the two PWM waveforms: the pair used for the positive half-wave or the pair used for the negative half-wave. The same bit drives the matching unfolding switch. An enable input holds all gates low and parks both counters. A period-start strobe marks each valley so that the controller can time its next duty update.

The duty port has no back-pressure beyond the enable. `duty_ready` follows `en`. A word is taken in every cycle where `duty_valid` and `duty_ready` are both high, and a newer word overwrites an older one that has not yet reached the active register. A word offered while the block is disabled is dropped.

Top module: `dualcarrier_pwm`

## Requirements
- R1: Carrier A leaves reset at 0 counting up. Every enabled clock it moves by one count between 0 and the peak H (`HALF_CNT`), and it reverses at both ends (0,1,…,H,H-1,…,1). One switching period is therefore 2H clocks.
- R2: Carrier B leaves reset at H counting down and follows the same rule, so it lags carrier A by exactly H clocks and the two carriers always sum to H. A reference of 1 makes `pos_b` pulse exactly H clocks after `pos_a` pulses at the valley.
- R3: A duty fraction d of `DUTY_W` bits is scaled to the reference r = ceil(d·(H+1)/2^DUTY_W), capped at H+1. Over one period each PWM output is high for 0 clocks when r = 0, for 2H clocks when r = H+1, and for 2r-1 clocks otherwise. So an all-zero duty keeps the outputs low and an all-ones duty keeps them high.
- R4: PWM A is high while the active reference is greater than carrier A, and PWM B is high while it is greater than carrier B. The two therefore carry the same number of high clocks per period.
- R5: An accepted duty goes into the shadow register. The active reference takes the shadow value only on the clock edge at the end of a cycle in which carrier A is 0. A word accepted mid-period has no effect before the next valley. A word accepted in the valley cycle itself waits a full period, and the previous value governs the coming period.
- R6: `duty_ready` equals `en`. A duty offered while `en` is low is not taken.
- R7: `grid_neg` is registered once. When the registered value is 0 (grid zero or positive), `pos_a`/`pos_b` carry PWM A/B, `pos_unf` is 1 and all `neg_*` outputs are 0. When it is 1, `neg_a`/`neg_b`/`neg_unf` take those roles and all `pos_*` outputs are 0.
- R8: While `en` is low, all six gates and `period_start` are low and both carriers are held at their reset values. The first enabled cycle is therefore a valley.
- R9: `period_start` is high for exactly one clock in every cycle where the block is enabled and carrier A is 0, which is once every 2H clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low parks counters and silences gates |
| duty_valid | input | 1 | Duty word offered |
| duty_ready | output | 1 | Duty port accepts (equals en) |
| duty_frac | input | DUTY_W | Unsigned duty fraction, full scale = all ones |
| grid_neg | input | 1 | Grid sample sign: 1 = negative |
| pos_a | output | 1 | Positive-half switch on carrier A |
| pos_b | output | 1 | Positive-half switch on carrier B |
| pos_unf | output | 1 | Positive-half unfolding switch |
| neg_a | output | 1 | Negative-half switch on carrier A |
| neg_b | output | 1 | Negative-half switch on carrier B |
| neg_unf | output | 1 | Negative-half unfolding switch |
| period_start | output | 1 | One-clock strobe at each carrier A valley |

## Verification
Accepting a duty word and copying the shadow into the active reference can happen in the same cycle, namely when the controller answers a `period_start` strobe at once. The bench provokes this by offering a new duty during the strobe cycle itself. It then counts the high clocks of the PWM output over the next full period and over the period after that. The first count must match the old reference and the second the new one. A mid-period write is also checked: its value must not appear before the following valley.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;

  typedef enum logic {
    SLOPE_DN = 1'b0,
    SLOPE_UP = 1'b1
  } slope_e;

endpackage

// File: rtl/dcpwm_carrier.sv
// Triangular carrier: an up/down counter that reverses at 0 and at PEAK.
// START_HIGH selects the starting extreme and direction (A: low/up, B: high/down).
module dcpwm_carrier
  import dcpwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PEAK       = 3750,
  parameter bit START_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output slope_e           slope
);

  localparam logic [CNT_W-1:0] PEAK_V    = CNT_W'(PEAK);
  localparam logic [CNT_W-1:0] TURN_HI   = CNT_W'(PEAK - 1);
  localparam logic [CNT_W-1:0] TURN_LO   = CNT_W'(1);
  localparam logic [CNT_W-1:0] START_VAL = START_HIGH ? PEAK_V : '0;
  localparam slope_e           START_SL  = START_HIGH ? SLOPE_DN : SLOPE_UP;

  logic [CNT_W-1:0] cnt_nx;
  slope_e           slope_nx;

  always_comb begin
    cnt_nx   = cnt;
    slope_nx = slope;
    if (!run) begin
      cnt_nx   = START_VAL;
      slope_nx = START_SL;
    end else if (slope == SLOPE_UP) begin
      cnt_nx = cnt + 1'b1;
      if (cnt == TURN_HI) slope_nx = SLOPE_DN;
    end else begin
      cnt_nx = cnt - 1'b1;
      if (cnt == TURN_LO) slope_nx = SLOPE_UP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= START_VAL;
      slope <= START_SL;
    end else begin
      cnt   <= cnt_nx;
      slope <= slope_nx;
    end
  end

endmodule

// File: rtl/dcpwm_refpath.sv
// Duty scaling (ceiling, capped at PEAK+1), shadow register and valley-timed
// transfer into the active compare register.
module dcpwm_refpath #(
  parameter int CNT_W  = 16,
  parameter int DUTY_W = 16,
  parameter int PEAK   = 3750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DUTY_W-1:0] duty,
  input  logic              valley,
  output logic [CNT_W-1:0]  act_ref
);

  localparam int               PROD_W = DUTY_W + CNT_W + 1;
  localparam logic [PROD_W-1:0] MULT  = PROD_W'(PEAK + 1);
  localparam logic [PROD_W-1:0] ROUND = PROD_W'((64'd1 << DUTY_W) - 64'd1);
  localparam logic [PROD_W-1:0] LIMIT = PROD_W'(PEAK + 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [CNT_W-1:0]  scaled;
  logic [CNT_W-1:0]  shadow;

  always_comb begin
    prod   = {{(PROD_W-DUTY_W){1'b0}}, duty} * MULT + ROUND;
    quot   = prod >> DUTY_W;
    scaled = (quot > LIMIT) ? LIMIT[CNT_W-1:0] : quot[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      act_ref <= '0;
    end else begin
      if (take)   shadow  <= scaled;
      if (valley) act_ref <= shadow;
    end
  end

endmodule

// File: rtl/dcpwm_gates.sv
// Comparators and polarity steering onto the two switch pairs.
module dcpwm_gates #(
  parameter int CNT_W = 16
) (
  input  logic             en,
  input  logic             neg_q,
  input  logic [CNT_W-1:0] act_ref,
  input  logic [CNT_W-1:0] car_a,
  input  logic [CNT_W-1:0] car_b,
  output logic             pos_a,
  output logic             pos_b,
  output logic             pos_unf,
  output logic             neg_a,
  output logic             neg_b,
  output logic             neg_unf
);

  logic pwm_a;
  logic pwm_b;
  logic side_pos;
  logic side_neg;

  always_comb begin
    pwm_a    = act_ref > car_a;
    pwm_b    = act_ref > car_b;
    side_pos = en & ~neg_q;
    side_neg = en &  neg_q;
    pos_a    = pwm_a & side_pos;
    pos_b    = pwm_b & side_pos;
    pos_unf  = side_pos;
    neg_a    = pwm_a & side_neg;
    neg_b    = pwm_b & side_neg;
    neg_unf  = side_neg;
  end

endmodule

// File: rtl/dualcarrier_pwm.sv
module dualcarrier_pwm
  import dcpwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HALF_CNT = 3750,
  parameter int DUTY_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              duty_valid,
  output logic              duty_ready,
  input  logic [DUTY_W-1:0] duty_frac,
  input  logic              grid_neg,
  output logic              pos_a,
  output logic              pos_b,
  output logic              pos_unf,
  output logic              neg_a,
  output logic              neg_b,
  output logic              neg_unf,
  output logic              period_start
);

  logic [CNT_W-1:0] car_a;
  logic [CNT_W-1:0] car_b;
  logic [CNT_W-1:0] act_ref;
  slope_e           slope_a;
  slope_e           slope_b;
  logic             neg_q;
  logic             valley;

  dcpwm_carrier #(.CNT_W(CNT_W), .PEAK(HALF_CNT), .START_HIGH(1'b0)) car_a_i (
    .clk(clk), .rst_n(rst_n), .run(en), .cnt(car_a), .slope(slope_a)
  );

  dcpwm_carrier #(.CNT_W(CNT_W), .PEAK(HALF_CNT), .START_HIGH(1'b1)) car_b_i (
    .clk(clk), .rst_n(rst_n), .run(en), .cnt(car_b), .slope(slope_b)
  );

  assign valley       = (car_a == '0);
  assign duty_ready   = en;
  assign period_start = en & valley;

  dcpwm_refpath #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .PEAK(HALF_CNT)) ref_i (
    .clk(clk), .rst_n(rst_n), .take(duty_valid & duty_ready),
    .duty(duty_frac), .valley(valley), .act_ref(act_ref)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= grid_neg;
  end

  dcpwm_gates #(.CNT_W(CNT_W)) gates_i (
    .en(en), .neg_q(neg_q), .act_ref(act_ref), .car_a(car_a), .car_b(car_b),
    .pos_a(pos_a), .pos_b(pos_b), .pos_unf(pos_unf),
    .neg_a(neg_a), .neg_b(neg_b), .neg_unf(neg_unf)
  );

endmodule

// File: rtl/dcpwm_chk.sv
module dcpwm_chk #(
  parameter int CNT_W = 16,
  parameter int PEAK  = 3750
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             duty_ready,
  input logic [CNT_W-1:0] car_a,
  input logic [CNT_W-1:0] car_b,
  input logic [CNT_W-1:0] act_ref,
  input logic             pos_a,
  input logic             pos_b,
  input logic             pos_unf,
  input logic             neg_a,
  input logic             neg_b,
  input logic             neg_unf,
  input logic             period_start
);

  p_bounds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (car_a <= CNT_W'(PEAK)) && (car_b <= CNT_W'(PEAK)));

  p_carriers_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, car_a} + {1'b0, car_b}) == (CNT_W+1)'(PEAK));

  p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_ref) |-> ($past(car_a) == '0));

  p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    duty_ready == en);

  p_side_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !((pos_a | pos_b | pos_unf) && (neg_a | neg_b | neg_unf)));

  p_unfold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pos_unf ^ neg_unf));

  p_gates_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(pos_a | pos_b | pos_unf | neg_a | neg_b | neg_unf | period_start));

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

endmodule

bind dualcarrier_pwm dcpwm_chk #(.CNT_W(CNT_W), .PEAK(HALF_CNT)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .duty_ready(duty_ready),
  .car_a(car_a), .car_b(car_b), .act_ref(act_ref),
  .pos_a(pos_a), .pos_b(pos_b), .pos_unf(pos_unf),
  .neg_a(neg_a), .neg_b(neg_b), .neg_unf(neg_unf),
  .period_start(period_start)
);

// File: tb/dualcarrier_pwm_tb_top.sv
module dualcarrier_pwm_tb_top;

  localparam int H   = 8;
  localparam int PER = 2 * H;
  localparam int CW  = 16;
  localparam int DW  = 8;
  localparam int NV  = 8;

  // Stimulus / expected-result vectors: duty, grid sign, high clocks per period
  // (R3: r = ceil(d*9/256), high = 0 | 2r-1 | 16 when r = 9).
  localparam logic [DW-1:0] V_DUTY [NV] = '{8'd128, 8'd64, 8'd0, 8'd255,
                                            8'd1, 8'd227, 8'd228, 8'd200};
  localparam logic          V_NEG  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1,
                                            1'b0, 1'b1, 1'b0, 1'b1};
  localparam int            V_HIGH [NV] = '{9, 5, 0, 16, 1, 15, 16, 15};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          duty_valid = 1'b0;
  logic [DW-1:0] duty_frac = '0;
  logic          grid_neg = 1'b0;
  logic          duty_ready;
  logic          pos_a, pos_b, pos_unf, neg_a, neg_b, neg_unf;
  logic          period_start;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dualcarrier_pwm #(.CNT_W(CW), .HALF_CNT(H), .DUTY_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .duty_valid(duty_valid),
    .duty_ready(duty_ready), .duty_frac(duty_frac), .grid_neg(grid_neg),
    .pos_a(pos_a), .pos_b(pos_b), .pos_unf(pos_unf),
    .neg_a(neg_a), .neg_b(neg_b), .neg_unf(neg_unf),
    .period_start(period_start)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_valley();
    int n = 0;
    while (!period_start && n < 4 * PER) begin
      tick();
      n++;
    end
    if (!period_start) chk("R9 valley strobe reached", 0, 1);
  endtask

  task automatic count_period(output int ca, output int cb, output int cu,
                              output int na, output int nb, output int nu);
    ca = 0; cb = 0; cu = 0; na = 0; nb = 0; nu = 0;
    for (int i = 0; i < PER; i++) begin
      ca += int'(pos_a);  cb += int'(pos_b);  cu += int'(pos_unf);
      na += int'(neg_a);  nb += int'(neg_b);  nu += int'(neg_unf);
      tick();
    end
  endtask

  task automatic run_entry(input logic [DW-1:0] d, input logic ng, input int exp);
    int ca, cb, cu, na, nb, nu;
    duty_frac  = d;
    duty_valid = 1'b1;
    grid_neg   = ng;
    tick();
    duty_valid = 1'b0;
    wait_valley();
    tick();
    count_period(ca, cb, cu, na, nb, nu);
    if (!ng) begin
      chk("R3 pwm A high clocks (pos side)", ca, exp);
      chk("R4 pwm B high clocks (pos side)", cb, exp);
      chk("R7 neg side silent", na + nb + nu, 0);
      chk("R7 pos unfold held on", cu, PER);
    end else begin
      chk("R3 pwm A high clocks (neg side)", na, exp);
      chk("R4 pwm B high clocks (neg side)", nb, exp);
      chk("R7 pos side silent", ca + cb + cu, 0);
      chk("R7 neg unfold held on", nu, PER);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int ca, cb, cu, na, nb, nu;
    int acc;

    // Reset state and disabled state (R8, R6)
    @(negedge clk);
    tick(); tick();
    chk("R8 gates low in reset", pos_a + pos_b + pos_unf + neg_a + neg_b + neg_unf, 0);
    chk("R9 strobe low in reset", period_start, 0);
    chk("R6 ready low in reset", duty_ready, 0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R8 gates low while disabled", pos_a + pos_b + pos_unf + neg_a + neg_b + neg_unf, 0);

    // Enable: valley at once, then period length (R8, R6, R1, R9)
    en = 1'b1;
    #1;
    chk("R8 first enabled cycle is valley", period_start, 1);
    chk("R6 ready follows enable", duty_ready, 1);
    tick();
    n = 1;
    while (!period_start && n < 4 * PER) begin
      tick();
      n++;
    end
    chk("R1 R9 valley spacing", n, PER);

    // Vector table (R3, R4, R7)
    for (int k = 0; k < NV; k++) run_entry(V_DUTY[k], V_NEG[k], V_HIGH[k]);

    // Interleave: ref = 1 gives single-clock pulses at each carrier's zero (R2)
    duty_frac = 8'd1; duty_valid = 1'b1; grid_neg = 1'b0;
    tick();
    duty_valid = 1'b0;
    wait_valley();
    tick();
    wait_valley();
    chk("R2 pos_a pulse at carrier A valley", pos_a, 1);
    n = 0;
    tick(); n++;
    while (!pos_b && n < 4 * PER) begin
      tick();
      n++;
    end
    chk("R2 carrier B lag in clocks", n, H);

    // Duty accepted in the valley cycle itself: old reference governs (R5)
    wait_valley();
    duty_frac = 8'd0; duty_valid = 1'b1;
    tick();
    duty_valid = 1'b0;
    count_period(ca, cb, cu, na, nb, nu);
    chk("R5 valley collision keeps old ref", ca, 1);
    count_period(ca, cb, cu, na, nb, nu);
    chk("R5 new ref after following valley", ca, 0);

    // Mid-period write held back until the next valley (R5)
    wait_valley();
    tick(); tick(); tick();
    duty_frac = 8'd255; duty_valid = 1'b1;
    tick();
    duty_valid = 1'b0;
    acc = 0;
    n = 0;
    while (!period_start && n < 4 * PER) begin
      acc += int'(pos_a);
      tick();
      n++;
    end
    chk("R5 mid-period write not yet active", acc, 0);
    chk("R5 valley cycle still old ref", pos_a, 0);
    tick();
    count_period(ca, cb, cu, na, nb, nu);
    chk("R5 mid-period write active next period", ca, PER);

    // Grid sign is registered (R7)
    grid_neg = 1'b1;
    #1;
    chk("R7 sign not yet applied", pos_unf, 1);
    tick();
    chk("R7 sign applied after one clock", neg_unf, 1);
    chk("R7 pos unfold released", pos_unf, 0);

    // Disable: gates quiet, offered duty dropped, restart at valley (R8, R6)
    en = 1'b0;
    #1;
    chk("R8 gates low on disable", pos_a + pos_b + pos_unf + neg_a + neg_b + neg_unf, 0);
    duty_frac = 8'd0; duty_valid = 1'b1;
    chk("R6 ready low while disabled", duty_ready, 0);
    tick();
    duty_valid = 1'b0;
    tick();
    en = 1'b1;
    #1;
    chk("R8 restart at valley", period_start, 1);
    count_period(ca, cb, cu, na, nb, nu);
    chk("R6 duty offered while disabled dropped", na, PER);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule